// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block derives a slower clock from a fast reference clock. In single mode every output period has the same integer length. In dual mode the block runs a repeating pattern. First comes a group of periods at one divisor, then a group at a second divisor, and each group has its own programmed length. The average ratio is therefore a fraction. A typical use is an accurate 32.768 kHz low-power clock made from a reference that is not an integer multiple of that rate. Over one dual pattern the average output frequency is f_in·(ma + mb) / (na·ma + nb·mb).

Both divisors, both repeat counts and the mode bit arrive as static configuration inputs. Each is written as its true value minus one. The block copies them into shadow registers, and a copy is taken only when a pattern ends, so a running pattern is never disturbed. All logic runs on the reference clock. The divided output and the period strobe are both register outputs.

Top module: `frac_clk_div`

## Requirements
- R1: While rst_n is low at a clock edge, clk_out and period_start are low after that edge. The first output period starts in the cycle that follows the first edge with rst_n high, and it uses divisor A.
- R2: With the shadowed mode bit at 0 (single mode), every output period lasts cfg_div_a + 1 reference cycles.
- R3: With the shadowed mode bit at 1 (dual mode), the block repeats one pattern without end: cfg_rep_a + 1 periods of cfg_div_a + 1 cycles each, then cfg_rep_b + 1 periods of cfg_div_b + 1 cycles each.
- R4: Every configuration field is the true value minus one. A field value of 0 gives a divisor of 1 or a repeat count of 1.
- R5: In a period of n cycles, clk_out is high for the first max(1, floor(n/2)) cycles and low for the rest. With n = 1, clk_out stays high.
- R6: period_start is high for exactly one cycle, the first cycle of each output period, and clk_out is always high in that cycle.
- R7: A change of the divisor or repeat fields has no effect until the current pattern ends. In dual mode the pattern ends after the last divisor-B period; in single mode it ends after each period.
- R8: A change of cfg_dual also takes effect only at a pattern boundary. After the change, the next period is the first divisor-A period of the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dual | input | 1 | Mode: 0 = single divisor, 1 = alternate two divisors |
| cfg_div_a | input | DIV_W | Divisor A minus one |
| cfg_div_b | input | DIV_W | Divisor B minus one |
| cfg_rep_a | input | REP_W | Number of divisor-A periods minus one |
| cfg_rep_b | input | REP_W | Number of divisor-B periods minus one |
| clk_out | output | 1 | Divided clock |
| period_start | output | 1 | One-cycle strobe in the first cycle of each output period |

## Verification
The embedded assertions check on every cycle that the outputs are low after reset, that the strobe always falls in a high cycle of clk_out, that the in-period and repeat counters never pass their shadowed limits, and that the shadow copy stays unchanged except when a pattern ends. The exact length and duty of each period, the order of the A and B groups, and the moment a new configuration is adopted can only be shown by the bench's scenarios. The bench covers these by measuring whole sequences of periods and comparing them with sequences it computes from the configuration fields.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int DIV_W = 8,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic [DIV_W-1:0] cfg_div_a,
  input  logic [DIV_W-1:0] cfg_div_b,
  input  logic [REP_W-1:0] cfg_rep_a,
  input  logic [REP_W-1:0] cfg_rep_b,
  output logic             clk_out,
  output logic             period_start
);

  logic             sh_dual;
  logic [DIV_W-1:0] sh_div_a, sh_div_b;
  logic [REP_W-1:0] sh_rep_a, sh_rep_b;

  logic [DIV_W-1:0] cyc;
  logic [REP_W-1:0] rep;
  logic             in_b;

  logic [DIV_W-1:0] cur_div;
  logic [REP_W-1:0] cur_rep;
  logic [DIV_W:0]   high_len;
  logic             end_per, end_grp, pat_end;

  assign cur_div  = in_b ? sh_div_b : sh_div_a;
  assign cur_rep  = in_b ? sh_rep_b : sh_rep_a;
  assign high_len = (cur_div == '0) ? (DIV_W+1)'(1) : ({1'b0, cur_div} + 1'b1) >> 1;
  assign end_per  = (cyc == cur_div);
  assign end_grp  = end_per && (rep == cur_rep);
  // a pattern closes after every period in single mode, after the B group in dual mode
  assign pat_end  = end_per && (!sh_dual || (in_b && end_grp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc          <= '0;
      rep          <= '0;
      in_b         <= 1'b0;
      clk_out      <= 1'b0;
      period_start <= 1'b0;
      sh_dual      <= cfg_dual;
      sh_div_a     <= cfg_div_a;
      sh_div_b     <= cfg_div_b;
      sh_rep_a     <= cfg_rep_a;
      sh_rep_b     <= cfg_rep_b;
    end else begin
      clk_out      <= ({1'b0, cyc} < high_len);
      period_start <= (cyc == '0);
      if (!end_per) begin
        cyc <= cyc + 1'b1;
      end else begin
        cyc <= '0;
        if (pat_end) begin
          rep  <= '0;
          in_b <= 1'b0;
        end else if (end_grp) begin
          rep  <= '0;
          in_b <= 1'b1;
        end else begin
          rep  <= rep + 1'b1;
        end
      end
      if (pat_end) begin
        sh_dual  <= cfg_dual;
        sh_div_a <= cfg_div_a;
        sh_div_b <= cfg_div_b;
        sh_rep_a <= cfg_rep_a;
        sh_rep_b <= cfg_rep_b;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!clk_out && !period_start));

  p_strobe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> clk_out);

  p_cyc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc <= cur_div);

  p_rep_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_dual |-> (rep <= cur_rep));

  p_single_in_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_dual |-> (!in_b && rep == '0));

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_end |=> ($stable(sh_div_a) && $stable(sh_div_b) && $stable(sh_rep_a)
                  && $stable(sh_rep_b) && $stable(sh_dual)));

endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
  localparam int DIV_W = 8;
  localparam int REP_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dual = 1'b0;
  logic [DIV_W-1:0] cfg_div_a = '0, cfg_div_b = '0;
  logic [REP_W-1:0] cfg_rep_a = '0, cfg_rep_b = '0;
  logic clk_out, period_start;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  frac_clk_div #(.DIV_W(DIV_W), .REP_W(REP_W)) u_frac_clk_div (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual),
    .cfg_div_a(cfg_div_a), .cfg_div_b(cfg_div_b),
    .cfg_rep_a(cfg_rep_a), .cfg_rep_b(cfg_rep_b),
    .clk_out(clk_out), .period_start(period_start));

  // dual, div_a, div_b, rep_a, rep_b
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0, 4, 0, 0, 0},
    '{0, 0, 9, 3, 3},
    '{1, 2, 3, 2, 1},
    '{1, 5, 6, 0, 0},
    '{1, 0, 1, 1, 2},
    '{0, 7, 2, 5, 5}
  };

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int hi_of(input int n);
    return (n == 1) ? 1 : n / 2;
  endfunction

  task automatic apply(input int d, input int da, input int db, input int ra, input int rb);
    cfg_dual  = d[0];
    cfg_div_a = DIV_W'(da);
    cfg_div_b = DIV_W'(db);
    cfg_rep_a = REP_W'(ra);
    cfg_rep_b = REP_W'(rb);
  endtask

  // leaves the bench at the negedge of the first cycle of the first period
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", int'(clk_out), 0, "clk_out in reset");
    check("R1", int'(period_start), 0, "period_start in reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // called at a negedge with period_start high; returns at the next start
  task automatic measure(output int len, output int hi);
    len = 0;
    hi = 0;
    do begin
      if (clk_out) hi++;
      len++;
      @(negedge clk);
    end while (!period_start && len < 1000);
  endtask

  task automatic expect_period(input string req, input int n);
    int len, hi;
    measure(len, hi);
    check(req, len, n, "period length");
    check("R5", hi, hi_of(n), "high cycles");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      do_reset();
      check("R1", int'(period_start), 1, "first start after release");
      check("R6", int'(clk_out), 1, "clk_out high at start");
      if (VEC[v][0] == 0) begin
        for (int p = 0; p < 3; p++) expect_period("R2 R4", VEC[v][1] + 1);
      end else begin
        for (int pat = 0; pat < 2; pat++) begin
          for (int a = 0; a <= VEC[v][3]; a++) expect_period("R3 R4", VEC[v][1] + 1);
          for (int b = 0; b <= VEC[v][4]; b++) expect_period("R3 R4", VEC[v][2] + 1);
        end
      end
    end

    // R6: strobe lasts a single cycle
    apply(0, 5, 0, 0, 0);
    do_reset();
    @(negedge clk);
    check("R6", int'(period_start), 0, "strobe second cycle");

    // R7 + R8: dual pattern 4,4,5 keeps running after a mid-pattern change to single n=2
    apply(1, 3, 4, 1, 0);
    do_reset();
    apply(0, 1, 9, 7, 7);
    expect_period("R7", 4);
    expect_period("R7", 4);
    expect_period("R7", 5);
    expect_period("R8", 2);
    expect_period("R8", 2);

    // R8: single n=6 switched to dual mid-period; the current period finishes first
    apply(0, 5, 0, 0, 0);
    do_reset();
    @(negedge clk);
    apply(1, 2, 1, 0, 1);
    begin
      int len, hi;
      measure(len, hi);
      check("R8", len + 1, 6, "old single period");
    end
    expect_period("R8", 3);
    expect_period("R8", 2);
    expect_period("R8", 2);
    expect_period("R8", 3);

    // R7: repeat-count change during dual mode waits for the B group to finish
    apply(1, 1, 2, 0, 0);
    do_reset();
    apply(1, 1, 2, 2, 0);
    expect_period("R7", 2);
    expect_period("R7", 3);
    expect_period("R7", 2);
    expect_period("R7", 2);
    expect_period("R7", 2);
    expect_period("R7", 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule